// File: doc/BRIEF.md
# Data Cache Maintenance Control Register

This block is the control word that software uses to steer a data cache. Software writes it through a plain write strobe and reads it back at any time. The block passes each field to the cache engine only under that field's own conditions. A full-cache invalidate request is accepted only while the cache is enabled. The range-maintenance command code can change only while no range operation is running. A start request is accepted only when the cache is enabled, both busy flags are low, and the command code already held in the register is one of the three defined range operations.

The invalidate and start bits are self-clearing requests. Each one sends a single-cycle trigger pulse to the engine in the cycle it becomes set. It then stays set until the engine's matching busy flag rises, and at that point the hardware clears it. Writing 0 to either bit does nothing. The word also holds an enable bit and a reset bit for each of four hit/miss event monitors (read hit, read miss, write hit, write miss), plus one bit that selects the burst type of the cache's outgoing read accesses. The outgoing writes always use incrementing bursts.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset, every field reads 0, every trigger and monitor-reset output is 0, the command output is 0, and the read-burst select is 0, which means incrementing bursts.
- R2: Bit 0 (full invalidate) becomes 1 on a write of 1 only if `cache_en` is 1 in that write cycle. With `cache_en` at 0, the write leaves the bit at 0.
- R3: Writing 0 to bit 0 does not clear it. The bit clears in the clock edge where `inval_busy` is first seen high after being low.
- R4: The command field, bits [4:2], takes the written value only when `cmd_busy` is 0. While `cmd_busy` is 1, a write leaves the field unchanged. Codes 1, 2 and 3 mean clean, invalidate, and clean-then-invalidate of a range. Codes 0 and 4 to 7 are reserved.
- R5: Bit 1 (start) becomes 1 on a write of 1 only when `cache_en`=1, `cmd_busy`=0 and `inval_busy`=0, and the command field held before the write is 1, 2 or 3. A command code written in the same word does not count.
- R6: Writing 0 to bit 1 does not clear it. The bit clears in the clock edge where `cmd_busy` is first seen high after being low.
- R7: `inval_pulse` and `start_pulse` are high for exactly one cycle: the first cycle in which their bit reads 1.
- R8: Monitor enable bits [8:5] (bit 5 read hit, 6 read miss, 7 write hit, 8 write miss) take any written value, independently, and drive `mon_en`.
- R9: Monitor reset bits [12:9] (same order) give a one-cycle pulse on `mon_rst` in the cycle after a write of 1, and they always read back as 0.
- R10: Bit 13 selects the read-burst type on `rd_burst_wrap` (0 incrementing, 1 wrapping). It takes any written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 14 | Write data |
| bus_rdata | output | 14 | Current control word |
| cache_en | input | 1 | Cache enabled, from the engine |
| inval_busy | input | 1 | Full invalidate in progress |
| cmd_busy | input | 1 | Range operation in progress |
| inval_pulse | output | 1 | Full-invalidate trigger |
| start_pulse | output | 1 | Range-operation trigger |
| cmd_code | output | 3 | Held range command code |
| mon_en | output | 4 | Monitor enables |
| mon_rst | output | 4 | Monitor reset pulses |
| rd_burst_wrap | output | 1 | Read burst type, 1 = wrapping |

## Verification
The bench tries a start in the same word that first writes a valid command code. A design that checked the incoming code would accept that start and emit a stray trigger. It writes 0 to both request bits while they are pending, which catches a design that lets software cancel a request. It raises each busy flag while writes are going on, so a design that drops the busy gate on the command field, or that clears on the wrong flag, leaves a visibly wrong readback. It also checks that monitor resets read as 0 and pulse only once, and that a reserved code, a low enable or a busy engine each block a start.

// File: rtl/dcm_pkg.sv
// Shared definitions for the cache maintenance control register.
// Assumes: command codes are 3 bits wide and only codes 1..3 are defined.
package dcm_pkg;

    typedef enum logic [2:0] {
        MCMD_NONE        = 3'd0,
        MCMD_CLEAN       = 3'd1,
        MCMD_INVAL       = 3'd2,
        MCMD_CLEAN_INVAL = 3'd3
    } mcmd_e;

    // True for a defined range operation
    function automatic logic mcmd_valid(input logic [2:0] code);
        return (code == MCMD_CLEAN) || (code == MCMD_INVAL) ||
               (code == MCMD_CLEAN_INVAL);
    endfunction

endpackage

// File: rtl/dcm_trig_bit.sv
// Self-clearing request bit with a trigger pulse.
// The bit sets on a qualified write of 1. It clears when the busy input
// is seen rising. If a set and a clear land in the same cycle, the set wins.
// Assumes: busy comes from the engine and is synchronous to clk.
module dcm_trig_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_one,
    input  logic set_ok,
    input  logic busy,
    output logic bit_q,
    output logic pulse_q
);
    logic busy_d;
    logic set_now;

    // Qualified set request
    assign set_now = wr_one & set_ok;

    // Request bit, busy history and one-cycle trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            busy_d  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            busy_d  <= busy;
            pulse_q <= set_now & ~bit_q;
            if (set_now)
                bit_q <= 1'b1;
            else if (busy & ~busy_d)
                bit_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dcm_cmd_reg.sv
// Range-maintenance command field. It is writable only while no range
// operation is running. It also reports whether the held code is defined.
// Assumes: busy is synchronous to clk.
module dcm_cmd_reg #(
    parameter int CMD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             busy,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic             cmd_ok
);
    import dcm_pkg::*;

    // Held code, frozen while busy
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr && !busy)
            cmd_q <= wdata;
    end

    // Validity of the already-held code
    assign cmd_ok = mcmd_valid(cmd_q);
endmodule

// File: rtl/dcm_mon_ctl.sv
// Enable and reset control for a set of event monitors.
// Enables are plain storage. Resets are one-cycle pulses made from a write.
// Assumes: each monitor counter samples its reset on the next clock edge.
module dcm_mon_ctl #(
    parameter int NUM_MON = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [NUM_MON-1:0] en_wdata,
    input  logic [NUM_MON-1:0] rst_wdata,
    output logic [NUM_MON-1:0] en_q,
    output logic [NUM_MON-1:0] rst_q
);
    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
        // Per-monitor enable storage and reset pulse
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[m]  <= 1'b0;
                rst_q[m] <= 1'b0;
            end else begin
                rst_q[m] <= wr & rst_wdata[m];
                if (wr)
                    en_q[m] <= en_wdata[m];
            end
        end
    end
endmodule

// File: rtl/dcache_maint_ctrl.sv
// Cache maintenance control word.
// Gates software writes with the enable and busy conditions, raises trigger
// pulses toward the cache engine, holds the monitor and burst settings.
// Layout: request bits at 0..1, then command, monitor enables, monitor
// resets, burst select, packed upward.
// Assumes: status inputs are synchronous to clk.
module dcache_maint_ctrl #(
    parameter int CMD_W   = 3,
    parameter int NUM_MON = 4,
    localparam int CMD_LSB   = 2,
    localparam int MEN_LSB   = CMD_LSB + CMD_W,
    localparam int MRST_LSB  = MEN_LSB + NUM_MON,
    localparam int BURST_BIT = MRST_LSB + NUM_MON,
    localparam int REG_W     = BURST_BIT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               cache_en,
    input  logic               inval_busy,
    input  logic               cmd_busy,
    output logic               inval_pulse,
    output logic               start_pulse,
    output logic [CMD_W-1:0]   cmd_code,
    output logic [NUM_MON-1:0] mon_en,
    output logic [NUM_MON-1:0] mon_rst,
    output logic               rd_burst_wrap
);
    logic inval_q;
    logic start_q;
    logic cmd_ok;
    logic start_ok;

    // Start gate uses the code held before this write
    assign start_ok = cache_en & ~cmd_busy & ~inval_busy & cmd_ok;

    dcm_trig_bit u_inval (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_one  (bus_wr & bus_wdata[0]),
        .set_ok  (cache_en),
        .busy    (inval_busy),
        .bit_q   (inval_q),
        .pulse_q (inval_pulse)
    );

    dcm_trig_bit u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_one  (bus_wr & bus_wdata[1]),
        .set_ok  (start_ok),
        .busy    (cmd_busy),
        .bit_q   (start_q),
        .pulse_q (start_pulse)
    );

    dcm_cmd_reg #(.CMD_W(CMD_W)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .busy   (cmd_busy),
        .wdata  (bus_wdata[MEN_LSB-1:CMD_LSB]),
        .cmd_q  (cmd_code),
        .cmd_ok (cmd_ok)
    );

    dcm_mon_ctl #(.NUM_MON(NUM_MON)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .en_wdata  (bus_wdata[MRST_LSB-1:MEN_LSB]),
        .rst_wdata (bus_wdata[BURST_BIT-1:MRST_LSB]),
        .en_q      (mon_en),
        .rst_q     (mon_rst)
    );

    // Read-burst type select
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_burst_wrap <= 1'b0;
        else if (bus_wr)
            rd_burst_wrap <= bus_wdata[BURST_BIT];
    end

    // Readback word; monitor resets always read 0
    always_comb begin
        bus_rdata                          = '0;
        bus_rdata[0]                       = inval_q;
        bus_rdata[1]                       = start_q;
        bus_rdata[MEN_LSB-1:CMD_LSB]       = cmd_code;
        bus_rdata[MRST_LSB-1:MEN_LSB]      = mon_en;
        bus_rdata[BURST_BIT]               = rd_burst_wrap;
    end
endmodule

// File: rtl/dcm_checker.sv
// Property checker for the maintenance control word, bound to the top.
module dcm_checker #(
    parameter int CMD_W   = 3,
    parameter int NUM_MON = 4,
    parameter int REG_W   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               cache_en,
    input logic               inval_busy,
    input logic               cmd_busy,
    input logic               inval_pulse,
    input logic               start_pulse,
    input logic [CMD_W-1:0]   cmd_code,
    input logic [NUM_MON-1:0] mon_rst,
    input logic [REG_W-1:0]   bus_rdata
);
    AST_INVAL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |-> $past(cache_en)); // R2

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> $stable(cmd_code)); // R4

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(cache_en && !cmd_busy && !inval_busy)); // R5

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |=> !bus_rdata[1]); // R6

    AST_INVAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |=> !inval_pulse); // R7

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R7

    AST_MRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_rst != '0) |-> $past(bus_wr)); // R9
endmodule

bind dcache_maint_ctrl dcm_checker #(
    .CMD_W   (CMD_W),
    .NUM_MON (NUM_MON),
    .REG_W   (REG_W)
) u_chk (.*);

// File: tb/dcache_maint_ctrl_tb.sv
`timescale 1ns/1ps
module dcache_maint_ctrl_tb;
    localparam int W = 14;

    typedef enum int {S_RD, S_IP, S_SP, S_CMD, S_MEN, S_MRST, S_BURST} sel_e;
    typedef struct {
        sel_e        sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         cache_en = 1'b0;
    logic         inval_busy = 1'b0;
    logic         cmd_busy = 1'b0;
    logic         inval_pulse, start_pulse, rd_burst_wrap;
    logic [2:0]   cmd_code;
    logic [3:0]   mon_en, mon_rst;

    item_t sb_q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    dcache_maint_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cache_en(cache_en), .inval_busy(inval_busy),
        .cmd_busy(cmd_busy), .inval_pulse(inval_pulse),
        .start_pulse(start_pulse), .cmd_code(cmd_code), .mon_en(mon_en),
        .mon_rst(mon_rst), .rd_burst_wrap(rd_burst_wrap)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    S_RD:    act = 32'(bus_rdata);
                    S_IP:    act = 32'(inval_pulse);
                    S_SP:    act = 32'(start_pulse);
                    S_CMD:   act = 32'(cmd_code);
                    S_MEN:   act = 32'(mon_en);
                    S_MRST:  act = 32'(mon_rst);
                    default: act = 32'(rd_burst_wrap);
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%s actual=%0h expected=%0h",
                             it.req, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    // One clock with the given write, then settle
    task automatic tick(input logic wr, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr    = wr;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic exp(input sel_e s, input logic [31:0] v, input string r);
        item_t it;
        it.sel = s; it.exp = v; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #0.1;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b0, '0);
        // R1 reset state
        exp(S_RD, 0, "R1"); exp(S_IP, 0, "R1"); exp(S_SP, 0, "R1");
        exp(S_CMD, 0, "R1"); exp(S_MEN, 0, "R1"); exp(S_MRST, 0, "R1");
        exp(S_BURST, 0, "R1"); flush();

        // R2 invalidate ignored with cache disabled
        cache_en = 1'b0;
        tick(1'b1, 14'h1);
        exp(S_RD, 0, "R2"); exp(S_IP, 0, "R2"); flush();
        cache_en = 1'b1;
        tick(1'b1, 14'h1);
        exp(S_RD, 1, "R2"); exp(S_IP, 1, "R7"); flush();
        tick(1'b0, '0);
        exp(S_IP, 0, "R7"); exp(S_RD, 1, "R3"); flush();
        // R3 writing zero does not clear
        tick(1'b1, 14'h0);
        exp(S_RD, 1, "R3"); flush();
        inval_busy = 1'b1;
        tick(1'b0, '0);
        exp(S_RD, 0, "R3"); flush();
        inval_busy = 1'b0;
        tick(1'b0, '0);

        // R4 command write, then frozen while busy
        tick(1'b1, 14'(2 << 2));
        exp(S_CMD, 2, "R4"); exp(S_RD, 8, "R4"); flush();
        cmd_busy = 1'b1;
        tick(1'b1, 14'((3 << 2) | 2));
        exp(S_CMD, 2, "R4"); exp(S_RD, 8, "R5"); exp(S_SP, 0, "R5"); flush();
        cmd_busy = 1'b0;
        tick(1'b0, '0);

        // R5 start accepted with valid held code
        tick(1'b1, 14'((2 << 2) | 2));
        exp(S_RD, 10, "R5"); exp(S_SP, 1, "R7"); flush();
        tick(1'b0, '0);
        exp(S_SP, 0, "R7"); flush();
        // R6 writing zero keeps start; busy rise clears
        tick(1'b1, 14'(2 << 2));
        exp(S_RD, 10, "R6"); flush();
        cmd_busy = 1'b1;
        tick(1'b0, '0);
        exp(S_RD, 8, "R6"); flush();
        cmd_busy = 1'b0;
        tick(1'b0, '0);

        // R5 reserved code blocks start
        tick(1'b1, 14'h0);
        tick(1'b1, 14'h2);
        exp(S_RD, 0, "R5"); exp(S_SP, 0, "R5"); flush();
        // R5 code written in same word does not count
        tick(1'b1, 14'((1 << 2) | 2));
        exp(S_RD, 4, "R5"); exp(S_SP, 0, "R5"); flush();
        tick(1'b1, 14'((1 << 2) | 2));
        exp(S_RD, 6, "R5"); exp(S_SP, 1, "R5"); flush();
        cmd_busy = 1'b1;
        tick(1'b0, '0);
        exp(S_RD, 4, "R6"); flush();
        cmd_busy = 1'b0;
        tick(1'b0, '0);
        // R5 invalidate busy blocks start
        inval_busy = 1'b1;
        tick(1'b1, 14'((1 << 2) | 2));
        exp(S_RD, 4, "R5"); exp(S_SP, 0, "R5"); flush();
        inval_busy = 1'b0;
        tick(1'b0, '0);
        // R5 disabled cache blocks start
        cache_en = 1'b0;
        tick(1'b1, 14'((1 << 2) | 2));
        exp(S_RD, 4, "R5"); exp(S_SP, 0, "R5"); flush();
        cache_en = 1'b1;

        // R8 monitor enables
        tick(1'b1, 14'((4'b1010 << 5) | (1 << 2)));
        exp(S_MEN, 4'b1010, "R8"); exp(S_RD, 32'h144, "R8"); flush();
        tick(1'b1, 14'((4'b0101 << 5) | (1 << 2)));
        exp(S_MEN, 4'b0101, "R8"); exp(S_RD, 32'h0A4, "R8"); flush();

        // R9 monitor reset pulses and reads zero
        tick(1'b1, 14'((4'b0110 << 9) | (4'b0101 << 5) | (1 << 2)));
        exp(S_MRST, 4'b0110, "R9"); exp(S_RD, 32'h0A4, "R9"); flush();
        tick(1'b0, '0);
        exp(S_MRST, 0, "R9"); flush();

        // R10 burst select
        tick(1'b1, 14'((1 << 13) | (4'b0101 << 5) | (1 << 2)));
        exp(S_BURST, 1, "R10"); exp(S_RD, 32'h20A4, "R10"); flush();
        tick(1'b1, 14'((4'b0101 << 5) | (1 << 2)));
        exp(S_BURST, 0, "R10"); flush();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule